// File: doc/BRIEF.md
# Differential Clock-Stop Controller

This block drives a bank of differential clock outputs and can park any chosen subset of them cleanly and then bring them back. It runs from a free-running reference clock at twice the output rate. Each output pair toggles once per reference cycle while it runs. Each lane presents a true level, a complement level and a separate drive-enable for each leg, so a pad ring can place the pins in high impedance. An undriven leg is presented as logic 0.

A stop is requested on an active-low input that has no timing relationship to the reference clock. The request is first synchronized on the complement rising edges of the generated clock. A change then counts only when the synchronized level is the same at two consecutive complement rising edges, and this applies to both stop and release.

When a stop is accepted, the stoppable mask and the park-style bit are captured. Only the masked lanes park, each at the point in its cycle where its true leg is high. On release, all parked lanes restart on one common edge. An output-enable override floats every leg at once.

Top module: `dclk_stop_ctrl`

## Requirements
- R1: During and right after reset, every lane runs: true level 0, complement level 1, both drive-enables 1, and the stop filter holds the stop as released.
- R2: A running lane toggles its true level on every reference clock edge, keeps its complement level opposite, and holds both drive-enables at 1.
- R3: A change of `stop_req_n` is accepted only when its synchronized level is the same at two consecutive complement rising edges. A low pulse that lasts one reference cycle leaves every output unchanged.
- R4: After a stop is accepted, only lanes whose `stop_mask` bit was 1 at acceptance park. Unmasked lanes keep running.
- R5: With `tri_mode` 0 at acceptance, a parked lane drives true high (`en_t`=1, `clk_t`=1) and leaves complement undriven (`en_c`=0, `clk_c`=0).
- R6: With `tri_mode` 1 at acceptance, a parked lane leaves both legs undriven: all four lane bits are 0.
- R7: Parking and resuming never shorten a phase. A lane's true level changes only to the value of the running phase, and its complement level changes only to the inverse of that phase.
- R8: All parked lanes resume on the same reference edge. The delay from release of `stop_req_n` to resumed complement drive lies between 4 and 12 reference cycles (2 to 6 output periods).
- R9: With `tri_mode` 1 at acceptance, the true leg of each parked lane is driven high again one reference cycle before its complement drive returns.
- R10: While `oe_force` is 1, every drive-enable and every level output is 0, whatever the stop state or mode.
- R11: Changes to `stop_mask` or `tri_mode` while a stop is accepted have no effect until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, twice the output rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release by the surrounding logic |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| stop_mask | input | N_OUT | Per-lane stoppable flag, 1 = lane parks on stop |
| tri_mode | input | 1 | Park style: 0 = true high / complement floating, 1 = both floating |
| oe_force | input | 1 | Override, 1 = float every leg |
| clk_t | output | N_OUT | True level per lane |
| clk_c | output | N_OUT | Complement level per lane |
| en_t | output | N_OUT | True-leg drive-enable per lane |
| en_c | output | N_OUT | Complement-leg drive-enable per lane |

## Verification
The glitch and park properties assume that the override is steady across the two cycles they compare. They make no claim when `oe_force` has just moved. The stimulus toggles the override only in short, separated windows. The simultaneous-resume property relies on the filter never reaccepting a stop before a pending resume has fired. The stimulus cannot break this, because it holds each `stop_req_n` level for at least one reference cycle and the filter needs several complement edges to flip twice. All asynchronous edges are placed between clock edges, so the reference model and the synchronizer see the same sampled level.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    LANE_RUN  = 2'd0,
    LANE_PARK = 2'd1,
    LANE_WAKE = 2'd2
  } lane_st_e;

  typedef struct packed {
    logic lvl_t;
    logic lvl_c;
    logic en_t;
    logic en_c;
  } pin_s;
endpackage

// File: rtl/dcs_phase_gen.sv
module dcs_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o,
  output logic cmp_rise_o
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  // the complement leg rises on the edge that ends a high true phase
  assign phase_o    = phase_q;
  assign cmp_rise_o = phase_q;
endmodule

// File: rtl/dcs_stop_filter.sv
module dcs_stop_filter #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_rise,
  input  logic             stop_n_i,
  input  logic [N_OUT-1:0] mask_i,
  input  logic             tri_i,
  output logic             stop_acc_o,
  output logic [N_OUT-1:0] mask_lat_o,
  output logic             mode_lat_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hold_q;
  logic                   acc_q, acc_d;
  logic                   steady, take;
  logic [N_OUT-1:0]       mask_q;
  logic                   mode_q;

  always_comb begin
    sync_d[0] = stop_n_i;
    for (int k = 1; k < SYNC_STAGES; k++) sync_d[k] = sync_q[k-1];
    steady = (sync_q[LAST] == hold_q);
    acc_d  = steady ? ~sync_q[LAST] : acc_q;
    take   = acc_d & ~acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hold_q <= 1'b1;
      acc_q  <= 1'b0;
    end else if (cmp_rise) begin
      sync_q <= sync_d;
      hold_q <= sync_q[LAST];
      acc_q  <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= 1'b0;
    end else if (cmp_rise && take) begin
      mask_q <= mask_i;
      mode_q <= tri_i;
    end
  end

  assign stop_acc_o = acc_q;
  assign mask_lat_o = mask_q;
  assign mode_lat_o = mode_q;
endmodule

// File: rtl/dcs_lane.sv
module dcs_lane
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_rise,
  input  logic phase,
  input  logic stop_acc,
  input  logic park_en,
  input  logic park_float,
  input  logic oe_force,
  output logic out_t,
  output logic out_c,
  output logic drv_t,
  output logic drv_c
);
  lane_st_e st_q, st_d;
  pin_s     pin;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LANE_RUN:  if (cmp_rise && stop_acc && park_en) st_d = LANE_PARK;
      LANE_PARK: if (!stop_acc) begin
                   if (park_float)    st_d = LANE_WAKE;
                   else if (cmp_rise) st_d = LANE_RUN;
                 end
      LANE_WAKE: if (cmp_rise) st_d = LANE_RUN;
      default:   st_d = LANE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LANE_RUN;
    else        st_q <= st_d;
  end

  always_comb begin
    pin = '0;
    if (!oe_force) begin
      unique case (st_q)
        LANE_RUN:  pin = '{lvl_t: phase, lvl_c: ~phase, en_t: 1'b1, en_c: 1'b1};
        LANE_PARK: pin = park_float ? '0 : '{lvl_t: 1'b1, lvl_c: 1'b0, en_t: 1'b1, en_c: 1'b0};
        LANE_WAKE: pin = '{lvl_t: 1'b1, lvl_c: 1'b0, en_t: 1'b1, en_c: 1'b0};
        default:   pin = '0;
      endcase
    end
  end

  assign out_t = pin.lvl_t;
  assign out_c = pin.lvl_c;
  assign drv_t = pin.en_t;
  assign drv_c = pin.en_c;
endmodule

// File: rtl/dclk_stop_ctrl.sv
module dclk_stop_ctrl #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic [N_OUT-1:0] stop_mask,
  input  logic             tri_mode,
  input  logic             oe_force,
  output logic [N_OUT-1:0] clk_t,
  output logic [N_OUT-1:0] clk_c,
  output logic [N_OUT-1:0] en_t,
  output logic [N_OUT-1:0] en_c
);
  logic             phase;
  logic             cmp_rise;
  logic             stop_acc;
  logic [N_OUT-1:0] mask_lat;
  logic             mode_lat;

  dcs_phase_gen u_phase (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .phase_o    (phase),
    .cmp_rise_o (cmp_rise)
  );

  dcs_stop_filter #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .cmp_rise   (cmp_rise),
    .stop_n_i   (stop_req_n),
    .mask_i     (stop_mask),
    .tri_i      (tri_mode),
    .stop_acc_o (stop_acc),
    .mask_lat_o (mask_lat),
    .mode_lat_o (mode_lat)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    dcs_lane u_lane (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .cmp_rise   (cmp_rise),
      .phase      (phase),
      .stop_acc   (stop_acc),
      .park_en    (mask_lat[g]),
      .park_float (mode_lat),
      .oe_force   (oe_force),
      .out_t      (clk_t[g]),
      .out_c      (clk_c[g]),
      .drv_t      (en_t[g]),
      .drv_c      (en_c[g])
    );
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_force,
  input logic [N_OUT-1:0] out_t,
  input logic [N_OUT-1:0] out_c,
  input logic [N_OUT-1:0] drv_t,
  input logic [N_OUT-1:0] drv_c,
  input logic             phase,
  input logic             stop_acc,
  input logic [N_OUT-1:0] mask_lat,
  input logic             mode_lat
);
  AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) oe_force |-> (drv_t == '0 && drv_c == '0 && out_t == '0 && out_c == '0)); // R10
  AST_RESUME_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) (!oe_force && !$past(oe_force) && ((drv_c & ~$past(drv_c)) != '0)) |-> (&drv_c)); // R8
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n) (stop_acc && $past(stop_acc)) |-> ($stable(mask_lat) && $stable(mode_lat))); // R11

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    AST_TRUE_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (!oe_force && !$past(oe_force) && (out_t[i] != $past(out_t[i]))) |-> (out_t[i] == phase)); // R7
    AST_COMP_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (!oe_force && !$past(oe_force) && (out_c[i] != $past(out_c[i]))) |-> (out_c[i] == !phase)); // R7
    AST_PARK_GATED: assert property (@(posedge clk) disable iff (!rst_n) ($fell(drv_c[i]) && !oe_force && !$past(oe_force)) |-> ($past(stop_acc) && $past(mask_lat[i]))); // R4
    AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!oe_force && !drv_c[i] && !mode_lat) |-> (drv_t[i] && out_t[i])); // R5
    AST_PARK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) (!oe_force && !drv_t[i]) |-> (!drv_c[i] && !out_t[i] && !out_c[i])); // R6
    AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ($rose(drv_t[i]) && !oe_force && !$past(oe_force)) |=> (drv_c[i] || oe_force)); // R9
  end
endmodule

bind dclk_stop_ctrl dcs_checker #(.N_OUT(N_OUT)) u_dcs_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .oe_force (oe_force),
  .out_t    (clk_t),
  .out_c    (clk_c),
  .drv_t    (en_t),
  .drv_c    (en_c),
  .phase    (phase),
  .stop_acc (stop_acc),
  .mask_lat (mask_lat),
  .mode_lat (mode_lat)
);

// File: tb/tb_dclk_stop_ctrl.sv
`timescale 1ns/100ps
module tb_dclk_stop_ctrl;
  localparam int N = 4;
  localparam int SY = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         stop_n;
  logic [N-1:0] mask;
  logic         tri_m;
  logic         oe;
  logic [N-1:0] clk_t, clk_c, en_t, en_c;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  dclk_stop_ctrl #(.N_OUT(N), .SYNC_STAGES(SY)) dut (
    .clk_ref(clk), .rst_n(rst_n), .stop_req_n(stop_n), .stop_mask(mask),
    .tri_mode(tri_m), .oe_force(oe), .clk_t(clk_t), .clk_c(clk_c),
    .en_t(en_t), .en_c(en_c)
  );

  // behavioural reference: lane states 0 run, 1 parked, 2 waking
  int m_ph;
  int m_acc, m_oacc, m_mode;
  int m_st[N];
  int m_mlat[N];
  bit m_pipe[$];
  bit m_cr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_acc = 0; m_mode = 0;
      m_pipe.delete();
      for (int k = 0; k <= SY; k++) m_pipe.push_back(1'b1);
      for (int i = 0; i < N; i++) begin m_st[i] = 0; m_mlat[i] = 0; end
    end else begin
      m_cr = (m_ph == 1);
      m_oacc = m_acc;
      for (int i = 0; i < N; i++) begin
        case (m_st[i])
          0: if (m_cr && m_oacc == 1 && m_mlat[i] == 1) m_st[i] = 1;
          1: if (m_oacc == 0) begin
               if (m_mode == 1) m_st[i] = 2;
               else if (m_cr) m_st[i] = 0;
             end
          default: if (m_cr) m_st[i] = 0;
        endcase
      end
      if (m_cr) begin
        if (m_pipe[SY-1] == m_pipe[SY]) m_acc = m_pipe[SY-1] ? 0 : 1;
        if (m_oacc == 0 && m_acc == 1) begin
          for (int i = 0; i < N; i++) m_mlat[i] = mask[i];
          m_mode = tri_m;
        end
        m_pipe.push_front(stop_n);
        void'(m_pipe.pop_back());
      end
      m_ph = 1 - m_ph;
    end
  end

  task automatic expect_lane(input int i, output bit t, output bit c, output bit dt, output bit dc);
    t = 0; c = 0; dt = 0; dc = 0;
    if (!oe) begin
      case (m_st[i])
        0: begin t = (m_ph == 1); c = (m_ph == 0); dt = 1; dc = 1; end
        1: if (m_mode == 0) begin t = 1; dt = 1; end
        default: begin t = 1; dt = 1; end
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [N-1:0] et, ec, edt, edc;
      for (int i = 0; i < N; i++) begin
        bit a, b, c2, d;
        expect_lane(i, a, b, c2, d);
        et[i] = a; ec[i] = b; edt[i] = c2; edc[i] = d;
      end
      n_vec++;
      if ({clk_t, clk_c, en_t, en_c} !== {et, ec, edt, edc}) begin
        n_bad++;
        $display("FAIL %s t/c/et/ec got %b %b %b %b expected %b %b %b %b at %0t",
                 cur_req, clk_t, clk_c, en_t, en_c, et, ec, edt, edc, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_stop(input bit v);
    @(negedge clk); #0.7 stop_n = v;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [N-1:0] prev_t;
    rst_n = 1'b0; stop_n = 1'b1; mask = '0; tri_m = 1'b0; oe = 1'b0;
    tick(3);
    cur_req = "R1";
    chk(en_t == '1 && en_c == '1 && clk_t == '0 && clk_c == '1, "R1", "reset pins", {clk_t, clk_c, en_t, en_c}, 16'h0fff);
    rst_n = 1'b1;
    tick(1);
    chk(en_t == '1 && en_c == '1, "R1", "drive after reset", {en_t, en_c}, 8'hff);

    cur_req = "R2";
    tick(1); prev_t = clk_t; tick(1);
    chk(clk_t == ~prev_t && clk_c == prev_t, "R2", "toggle", clk_t, ~prev_t);

    // one-cycle low pulse must be filtered
    cur_req = "R3";
    mask = '1;
    drive_stop(1'b0); drive_stop(1'b1);
    for (int k = 0; k < 20; k++) begin
      tick(1);
      chk(en_c == '1, "R3", "complement drive during glitch", en_c, 4'hf);
    end

    // mode 0, partial mask
    cur_req = "R4";
    mask = 4'b0101; tri_m = 1'b0;
    drive_stop(1'b0);
    tick(16);
    chk(en_c == 4'b1010, "R4", "parked set", en_c, 4'b1010);
    chk(en_t == 4'b1111 && clk_t[0] && clk_t[2], "R5", "true high parked", {en_t, clk_t}, 8'hf5);
    cur_req = "R11";
    mask = 4'b1111; tri_m = 1'b1;
    tick(8);
    chk(en_c == 4'b1010 && en_t == 4'b1111, "R11", "latched mask/mode", {en_t, en_c}, 8'hfa);
    cur_req = "R10";
    @(negedge clk); #0.7 oe = 1'b1;
    tick(2);
    chk({clk_t, clk_c, en_t, en_c} == '0, "R10", "override during stop", {clk_t, clk_c, en_t, en_c}, 0);
    @(negedge clk); #0.7 oe = 1'b0;
    tick(3);
    cur_req = "R8";
    drive_stop(1'b1);
    lat = 0;
    while (en_c != '1 && lat < 40) begin tick(1); lat++; end
    chk(lat >= 4 && lat <= 12, "R8", "resume latency cycles", lat, 8);
    tick(1);
    chk(en_c == '1 && en_t == '1, "R8", "all running", {en_t, en_c}, 8'hff);

    // mode 1, full mask
    cur_req = "R6";
    tick(5);
    mask = 4'b1111; tri_m = 1'b1;
    drive_stop(1'b0);
    tick(16);
    chk({clk_t, clk_c, en_t, en_c} == '0, "R6", "floating park", {clk_t, clk_c, en_t, en_c}, 0);
    mask = 4'b0000; tri_m = 1'b0;
    cur_req = "R9";
    drive_stop(1'b1);
    lat = 0;
    while (en_t == '0 && lat < 40) begin tick(1); lat++; end
    chk(en_t == '1 && clk_t == '1 && en_c == '0, "R9", "true leg first", {en_t, clk_t, en_c}, 12'hff0);
    tick(1);
    chk(en_c == '1, "R9", "complement one cycle later", en_c, 4'hf);
    chk(lat >= 3 && lat <= 12, "R8", "mode1 resume latency", lat, 8);

    cur_req = "R10";
    tick(2);
    @(negedge clk); #0.7 oe = 1'b1;
    tick(1);
    chk(en_t == '0 && en_c == '0, "R10", "override running", {en_t, en_c}, 0);
    @(negedge clk); #0.7 oe = 1'b0;

    // random stop traffic, compared cycle by cycle
    cur_req = "R7";
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      #(0.3 + 0.1 * ($urandom % 14));
      stop_n = $urandom % 2;
      if ($urandom % 4 == 0) mask = N'($urandom);
      if ($urandom % 5 == 0) tri_m = $urandom % 2;
      if ($urandom % 23 == 0) oe = 1'b1;
      else if (oe && ($urandom % 2 == 0)) oe = 1'b0;
      repeat ($urandom % 12) @(negedge clk);
    end
    oe = 1'b0; stop_n = 1'b1;
    tick(20);
    chk(en_t == '1 && en_c == '1, "R7", "idle after traffic", {en_t, en_c}, 8'hff);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule